// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a serial memory slave engine and a 2048 x 8 storage array. While a write transfer is in progress the engine hands it a starting memory address and then one data byte at a time; the block keeps those bytes in a 16-slot page buffer. The low four address bits select the slot and step by one per byte. They wrap inside the page, so a seventeenth byte lands on top of the first. The upper address bits stay fixed for the whole transfer.

When the engine sees the stop condition it raises a commit request. The block then holds `busy` for a fixed interval of `COMMIT_CYCLES` clock cycles, which models the internally timed programming cycle. At the tail end of that interval it drives the array write port once for every slot that actually received a byte. Slots that received nothing are never written. While busy, every request from the engine is ignored. A separate clear input drops the buffered bytes without programming anything, for example when write protection is active or the transfer was aborted.

Top module: `page_commit_buf`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and the buffer holds no bytes, so a commit request straight after reset starts no commit.
- R2: `addr_load` records the page (address bits above the low four) and the starting slot (low four bits) and empties the buffer. Each accepted `byte_vld` stores `byte_in` in the current slot, marks it received and advances the slot by one.
- R3: The slot index wraps from 15 to 0 within the same page. A later byte replaces the data of an earlier one in that slot, and the page bits never change during a transfer.
- R4: A commit request with at least one received byte makes `busy` high from the next cycle for exactly `COMMIT_CYCLES` consecutive cycles.
- R5: During a commit `mem_we` is high in exactly the last N cycles of the busy window, where N is the number of received slots. The writes go in ascending slot order, and `busy` falls in the cycle right after the last write. `mem_we` is never high while `busy` is low.
- R6: Each write drives `mem_addr` = {page, slot} and `mem_data` = the last byte stored in that slot. Slots that received no byte are not written.
- R7: A commit request while the buffer is empty has no effect.
- R8: `clear` empties the buffer without any array write, so a following commit request starts nothing.
- R9: While `busy` is high, `addr_load`, `byte_vld`, `clear` and `commit_req` are all ignored.
- R10: When several requests meet in one idle cycle, `clear` wins over `commit_req`, which wins over `addr_load`, which wins over `byte_vld`. The losing requests are dropped.
- R11: When a commit finishes the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Strobe: take `addr_in` as page and start slot |
| addr_in | input | ADDR_W (11) | Received memory address |
| byte_vld | input | 1 | Strobe: one data byte received |
| byte_in | input | DATA_W (8) | Received data byte |
| commit_req | input | 1 | Stop seen: program the buffered bytes |
| clear | input | 1 | Drop buffered bytes without programming |
| busy | output | 1 | Timed commit in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W (11) | Array write address |
| mem_data | output | DATA_W (8) | Array write data |

## Verification
The embedded properties assume the strobes are sampled as plain synchronous levels. They also assume `COMMIT_CYCLES` is at least the page size, which an elaboration check enforces, so that the whole drain fits inside the busy window. The stimulus is driven on the falling edge and holds each strobe for exactly one cycle. It deliberately fires strobes during the busy window and in colliding combinations, to show the ignore and priority rules. The bench uses a short commit interval, so every window completes within the run.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
   // Default geometry: 2048 x 8 array, 16-byte pages
   localparam int DEF_ADDR_W     = 11;
   localparam int DEF_DATA_W     = 8;
   localparam int DEF_PAGE_BYTES = 16;
   // 5 ms at 125 MHz
   localparam int DEF_COMMIT_CYC = 625000;

   // Buffer action decoded once per cycle by the top
   typedef enum logic [1:0] {
      BUF_HOLD  = 2'd0,
      BUF_EMPTY = 2'd1,
      BUF_START = 2'd2,
      BUF_STORE = 2'd3
   } buf_op_e;
endpackage

// File: rtl/pcb_slot_store.sv
module pcb_slot_store
   import page_commit_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int SLOTS  = DEF_PAGE_BYTES,
   parameter int PAGE_W = DEF_ADDR_W - $clog2(DEF_PAGE_BYTES),
   localparam int OFS_W = $clog2(SLOTS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  buf_op_e                       op,
   input  logic [PAGE_W+OFS_W-1:0]       ld_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          drop_en,
   input  logic [OFS_W-1:0]              drop_idx,
   output logic [PAGE_W-1:0]             page_o,
   output logic [SLOTS-1:0][DATA_W-1:0]  slot_o,
   output logic [SLOTS-1:0]              valid_o
);
   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;

   // R2 / R3: page and slot pointer, pointer wraps by its own width
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (op == BUF_START) begin
         page_q <= ld_addr[PAGE_W+OFS_W-1:OFS_W];
         ofs_q  <= ld_addr[OFS_W-1:0];
      end else if (op == BUF_STORE) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic [DATA_W-1:0] byte_q;
         logic              got_q;
         logic              hit;
         assign hit = (ofs_q == OFS_W'(s));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
               got_q  <= 1'b0;
            end else begin
               if (op == BUF_STORE && hit) byte_q <= wr_data;
               if (op == BUF_EMPTY || op == BUF_START) got_q <= 1'b0;
               else if (op == BUF_STORE && hit)        got_q <= 1'b1;
               else if (drop_en && drop_idx == OFS_W'(s)) got_q <= 1'b0;
            end
         end
         assign slot_o[s]  = byte_q;
         assign valid_o[s] = got_q;
      end
   endgenerate

   assign page_o = page_q;

   // R3: a data byte never moves the page
   a_r3_page_fixed : assert property (@(posedge clk) disable iff (!rst_n)
      op == BUF_STORE |=> $stable(page_q));
endmodule

// File: rtl/pcb_pick.sv
module pcb_pick #(
   parameter int SLOTS = 16,
   localparam int OFS_W = $clog2(SLOTS),
   localparam int CW    = $clog2(SLOTS + 1)
) (
   input  logic [SLOTS-1:0] valid,
   output logic [OFS_W-1:0] low_idx,
   output logic [CW-1:0]    count,
   output logic             any
);
   // R5: lowest received slot drains first
   always_comb begin
      low_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (valid[i]) low_idx = OFS_W'(i);
      end
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < SLOTS; i++) begin
         count = count + CW'(valid[i]);
      end
   end

   assign any = |valid;
endmodule

// File: rtl/pcb_commit_timer.sv
module pcb_commit_timer #(
   parameter int COMMIT_CYCLES = 625000,
   parameter int CW            = 5,
   localparam int TW = $clog2(COMMIT_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] remain,
   output logic          busy,
   output logic          fire
);
   logic [TW-1:0] left_q;
   logic          busy_q;

   generate
      if (TW < CW) begin : g_bad_width
         $error("commit interval shorter than page drain");
      end
   endgenerate

   // R4: fixed-length busy window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (busy_q) begin
         if (left_q == '0) busy_q <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end else if (start) begin
         busy_q <= 1'b1;
         left_q <= TW'(COMMIT_CYCLES - 1);
      end
   end

   // R5: writes fill the tail of the window
   assign fire = busy_q && (left_q < TW'(remain));
   assign busy = busy_q;

   // R4: the window never ends early
   a_r4_hold_window : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && left_q != '0 |=> busy_q);
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
   import page_commit_pkg::*;
#(
   parameter int ADDR_W        = DEF_ADDR_W,
   parameter int DATA_W        = DEF_DATA_W,
   parameter int PAGE_BYTES    = DEF_PAGE_BYTES,
   parameter int COMMIT_CYCLES = DEF_COMMIT_CYC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              commit_req,
   input  logic              clear,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data
);
   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFS_W;
   localparam int CW     = $clog2(PAGE_BYTES + 1);

   generate
      if (PAGE_BYTES != (1 << OFS_W)) begin : g_bad_page
         $error("page size must be a power of two");
      end
      if (COMMIT_CYCLES < PAGE_BYTES) begin : g_bad_commit
         $error("commit interval must cover one write per slot");
      end
      if (PAGE_W < 1) begin : g_bad_addr
         $error("address narrower than one page");
      end
   endgenerate

   buf_op_e                         op;
   logic                            start, fire, any;
   logic [PAGE_W-1:0]               page;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] slots;
   logic [PAGE_BYTES-1:0]           valid;
   logic [OFS_W-1:0]                low_idx;
   logic [CW-1:0]                   count;

   // R9 / R10: idle-only, clear > commit > load > byte
   always_comb begin
      op    = BUF_HOLD;
      start = 1'b0;
      if (!busy) begin
         if (clear)          op = BUF_EMPTY;
         else if (commit_req) start = any;
         else if (addr_load) op = BUF_START;
         else if (byte_vld)  op = BUF_STORE;
      end
   end

   pcb_slot_store #(
      .DATA_W (DATA_W),
      .SLOTS  (PAGE_BYTES),
      .PAGE_W (PAGE_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .ld_addr  (addr_in),
      .wr_data  (byte_in),
      .drop_en  (fire),
      .drop_idx (low_idx),
      .page_o   (page),
      .slot_o   (slots),
      .valid_o  (valid)
   );

   pcb_pick #(.SLOTS(PAGE_BYTES)) u_pick (
      .valid   (valid),
      .low_idx (low_idx),
      .count   (count),
      .any     (any)
   );

   pcb_commit_timer #(
      .COMMIT_CYCLES (COMMIT_CYCLES),
      .CW            (CW)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .remain (count),
      .busy   (busy),
      .fire   (fire)
   );

   // R6: array port
   assign mem_we   = fire;
   assign mem_addr = {page, low_idx};
   assign mem_data = slots[low_idx];

   // R5: no write outside the window
   a_r5_we_in_window : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   // R5: window closes right after the final write
   a_r5_close_after_write : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_we));
   // R5: ascending slot order within one commit
   a_r5_ascending : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && $past(mem_we) |-> mem_addr[OFS_W-1:0] > $past(mem_addr[OFS_W-1:0]));
   // R11: nothing left behind
   a_r11_drained : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !any);
   // R7: empty commit starts nothing
   a_r7_empty_commit : assert property (@(posedge clk) disable iff (!rst_n)
      !busy && commit_req && !any |=> !busy);
   // R9: buffer contents frozen while busy
   a_r9_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(slots));
endmodule

// File: tb/sim_page_commit_buf.sv
module sim_page_commit_buf;
   localparam int C = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_load = 1'b0, byte_vld = 1'b0, commit_req = 1'b0, clear = 1'b0;
   logic [10:0] addr_in = '0;
   logic [7:0]  byte_in = '0;
   logic        busy, mem_we;
   logic [10:0] mem_addr;
   logic [7:0]  mem_data;

   int checks = 0, errors = 0, wr_seen = 0, cyc = 0;
   string phase = "R1 reset";

   always #4 clk = ~clk;   // 125 MHz

   page_commit_buf #(.COMMIT_CYCLES(C)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_vld(byte_vld), .byte_in(byte_in), .commit_req(commit_req),
      .clear(clear), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_data(mem_data));

   // ---------------- behavioural reference ----------------
   int m_data[16];
   bit m_val[16];
   int m_page = 0, m_ofs = 0, m_left = 0;
   bit m_busy = 0;
   int wq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_val[i]) m_val[i] = 0;
         m_busy = 0; m_ofs = 0; m_page = 0; m_left = 0;
         wq.delete();
      end else if (m_busy) begin
         if (m_left <= wq.size()) void'(wq.pop_front());
         m_left--;
         if (m_left == 0) m_busy = 0;
      end else if (clear) begin
         foreach (m_val[i]) m_val[i] = 0;
      end else if (commit_req) begin
         for (int i = 0; i < 16; i++)
            if (m_val[i]) wq.push_back((((m_page << 4) | i) << 8) | m_data[i]);
         if (wq.size() > 0) begin
            m_busy = 1; m_left = C;
            foreach (m_val[i]) m_val[i] = 0;
         end
      end else if (addr_load) begin
         m_page = addr_in >> 4; m_ofs = addr_in & 15;
         foreach (m_val[i]) m_val[i] = 0;
      end else if (byte_vld) begin
         m_data[m_ofs] = byte_in; m_val[m_ofs] = 1;
         m_ofs = (m_ofs + 1) % 16;
      end
   end

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s [%s] got %0h exp %0h", req, phase, got, exp);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_we;
         cyc++;
         exp_we = m_busy && (m_left <= wq.size());
         chk("R4 busy", int'(busy), int'(m_busy));
         chk("R5 mem_we", int'(mem_we), int'(exp_we));
         if (exp_we) begin
            chk("R6 mem_addr", int'(mem_addr), wq[0] >> 8);
            chk("R6 mem_data", int'(mem_data), wq[0] & 255);
         end
         if (mem_we) wr_seen++;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got 1 exp 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic do_load(int a);
      @(negedge clk); addr_load = 1; addr_in = 11'(a);
      @(negedge clk); addr_load = 0;
   endtask
   task automatic do_byte(int d);
      @(negedge clk); byte_vld = 1; byte_in = 8'(d);
      @(negedge clk); byte_vld = 0;
   endtask
   task automatic do_commit(string req, int exp_n);
      wr_seen = 0;
      @(negedge clk); commit_req = 1;
      @(negedge clk); commit_req = 0;
      idle(C + 3);
      chk(req, wr_seen, exp_n);
      chk(req, int'(busy), 0);
   endtask

   initial begin
      idle(2);
      rst_n = 1;
      @(negedge clk);
      phase = "R1 reset";
      chk("R1 busy", int'(busy), 0);
      chk("R1 we", int'(mem_we), 0);
      do_commit("R1 R7 empty commit", 0);

      phase = "R2 three bytes";
      do_load(11'h123);
      do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
      do_commit("R2 R6 write count", 3);

      phase = "R3 wrap overwrite";
      do_load(11'h3FE);
      for (int k = 0; k < 20; k++) do_byte(8'h40 + k);
      do_commit("R3 full page", 16);

      phase = "R5 R6 sparse wrap";
      do_load(11'h55E);
      for (int k = 0; k < 4; k++) do_byte(8'hC0 + k);
      do_commit("R5 R6 sparse", 4);

      phase = "R8 clear";
      do_load(11'h010);
      do_byte(8'h11); do_byte(8'h22);
      @(negedge clk); clear = 1; @(negedge clk); clear = 0;
      do_commit("R8 cleared", 0);

      phase = "R9 busy ignore";
      do_load(11'h200);
      do_byte(8'h77); do_byte(8'h88);
      wr_seen = 0;
      @(negedge clk); commit_req = 1; @(negedge clk); commit_req = 0;
      idle(2);
      @(negedge clk); addr_load = 1; addr_in = 11'h7F0; @(negedge clk); addr_load = 0;
      byte_vld = 1; byte_in = 8'hEE; @(negedge clk); byte_vld = 0;
      clear = 1; @(negedge clk); clear = 0;
      commit_req = 1; @(negedge clk); commit_req = 0;
      idle(C);
      chk("R9 writes kept", wr_seen, 2);
      do_commit("R9 R11 drained", 0);

      phase = "R10 clear beats byte";
      do_load(11'h300);
      do_byte(8'h5A);
      @(negedge clk); clear = 1; byte_vld = 1; byte_in = 8'h5B;
      @(negedge clk); clear = 0; byte_vld = 0;
      do_commit("R10 clear wins", 0);

      phase = "R10 commit beats byte";
      do_load(11'h310);
      do_byte(8'h6C);
      wr_seen = 0;
      @(negedge clk); commit_req = 1; byte_vld = 1; byte_in = 8'h6D;
      @(negedge clk); commit_req = 0; byte_vld = 0;
      idle(C + 3);
      chk("R10 commit wins", wr_seen, 1);
      do_commit("R10 R11 byte dropped", 0);

      phase = "R10 load beats byte";
      @(negedge clk); addr_load = 1; addr_in = 11'h420; byte_vld = 1; byte_in = 8'h99;
      @(negedge clk); addr_load = 0; byte_vld = 0;
      do_commit("R10 load wins", 0);

      idle(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule